// File: doc/BRIEF.md
# Reference-to-Tachometer Falling-Edge Phase Comparator

This block sits in a motor speed loop and compares a slow reference clock with a tachometer feedback signal taken from one Hall phase. Both inputs are asynchronous and noisy. Each one is synchronised to a fast system clock and then passed through a stability filter before its falling edges are found. Rising edges are never compared.

The comparator works as a phase-frequency detector with three output states. A reference falling edge that comes first raises a speed-up request. A feedback falling edge that comes first raises a slow-down request. The request stays high until the other signal's falling edge arrives, so the pulse width in system-clock cycles equals the phase error. When the loop settles, the two signals run at the same frequency.

Each finished comparison yields a width. A qualifier raises a raw lock flag after a run of consecutive comparisons whose width is below a programmable limit, and drops the flag on the first comparison that is not below it. A stop input holds every output low and clears all comparison and lock state.

Top module: `fg_phase_cmp`

## Requirements
- R1: After reset, `speed_up_o`, `slow_down_o` and `lock_raw_o` are all low.
- R2: When the filtered reference falls d cycles before the filtered feedback, `speed_up_o` is high for exactly d system-clock cycles and `slow_down_o` stays low.
- R3: When the filtered feedback falls d cycles before the filtered reference, `slow_down_o` is high for exactly d cycles and `speed_up_o` stays low.
- R4: Falling edges of both signals in the same cycle complete a comparison of width 0 and raise neither request.
- R5: Rising edges of either input have no effect on the request outputs.
- R6: An input excursion that lasts fewer than FILT_LEN consecutive system-clock cycles is rejected and produces no edge.
- R7: `speed_up_o` and `slow_down_o` are never high together.
- R8: Further reference falling edges that arrive while a speed-up request is open keep the request high until the next feedback falling edge. The mirror case holds for slow-down.
- R9: `lock_raw_o` rises one cycle after the LOCK_RUN-th consecutive comparison whose width is strictly below `lock_limit_i` (default LOCK_RUN = 8).
- R10: Any comparison whose width is greater than or equal to `lock_limit_i` clears `lock_raw_o` and restarts the consecutive-comparison count.
- R11: While `stop_i` is high, all three outputs are low from the next cycle on. Open requests and the lock run are cleared, so the first comparison after release starts a fresh run.
- R12: The comparison width saturates at 2^CNT_W-1 and does not wrap, so a very long error is never taken as a small one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both inputs |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Holds outputs inactive and clears state while high |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| fb_i | input | 1 | Asynchronous tachometer feedback |
| lock_limit_i | input | CNT_W | Width limit for a comparison to count toward lock |
| speed_up_o | output | 1 | Reference leads; request more speed |
| slow_down_o | output | 1 | Feedback leads; request less speed |
| lock_raw_o | output | 1 | Raw phase-locked indication |

## Verification
A wrong detector state shows up as a request pulse that is too long, too short or on the wrong output. This can be seen at the ports as soon as the closing edge has passed through the input filter, which takes about FILT_LEN plus three cycles. A corrupt width counter or lock run can only be seen in `lock_raw_o`, and only at the end of a run of LOCK_RUN comparisons. The bench therefore lines up good runs on either side of a failing comparison, a saturating comparison and a stop. The filter and synchroniser delays are the same on both inputs, so every pulse width is checked exactly against the spacing of the driven edges.

// File: rtl/fgpc_pkg.sv
`timescale 1ns/1ps
package fgpc_pkg;
  // detector state: which signal fell first and is still waiting for the other
  typedef enum logic [1:0] {
    PD_IDLE     = 2'd0,
    PD_REF_LEAD = 2'd1,
    PD_FB_LEAD  = 2'd2
  } pd_state_e;

  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/fgpc_deglitch.sv
`timescale 1ns/1ps
module fgpc_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic fall_o
);
  localparam int FW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [FW-1:0] LAST = FW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;
  logic [FW-1:0]          run_q;
  logic                   fall_q;

  // synchroniser chain, resets to the idle-high level
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // level changes only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      run_q   <= '0;
      fall_q  <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (sync_q[SYNC_STAGES-1] == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= sync_q[SYNC_STAGES-1];
        run_q   <= '0;
        fall_q  <= level_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign fall_o = fall_q;
endmodule

// File: rtl/fgpc_detector.sv
`timescale 1ns/1ps
module fgpc_detector
  import fgpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_i,
  input  logic             ref_fall_i,
  input  logic             fb_fall_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             done_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  pd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W-1:0] width_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      state_q <= PD_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      width_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PD_IDLE: begin
          if (ref_fall_i && fb_fall_i) begin
            done_q  <= 1'b1;
            width_q <= '0;
          end else if (ref_fall_i) begin
            state_q <= PD_REF_LEAD;
            cnt_q   <= CNT_W'(1);
          end else if (fb_fall_i) begin
            state_q <= PD_FB_LEAD;
            cnt_q   <= CNT_W'(1);
          end
        end
        PD_REF_LEAD: begin
          if (fb_fall_i) begin
            done_q  <= 1'b1;
            width_q <= cnt_q;
            if (ref_fall_i) cnt_q <= CNT_W'(1);
            else            state_q <= PD_IDLE;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        PD_FB_LEAD: begin
          if (ref_fall_i) begin
            done_q  <= 1'b1;
            width_q <= cnt_q;
            if (fb_fall_i) cnt_q <= CNT_W'(1);
            else           state_q <= PD_IDLE;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        default: state_q <= PD_IDLE;
      endcase
    end
  end

  assign up_o    = (state_q == PD_REF_LEAD);
  assign dn_o    = (state_q == PD_FB_LEAD);
  assign done_o  = done_q;
  assign width_o = width_q;
endmodule

// File: rtl/fgpc_lock_qual.sv
`timescale 1ns/1ps
module fgpc_lock_qual #(
  parameter int CNT_W    = 16,
  parameter int LOCK_RUN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             lock_o
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(LOCK_RUN);
  localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_RUN - 1);

  logic [RW-1:0] run_q;
  logic          lock_q;

  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (done_i) begin
      if (width_i < limit_i) begin
        if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
        if (run_q >= RUN_LAST) lock_q <= 1'b1;
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/fg_phase_cmp.sv
`timescale 1ns/1ps
module fg_phase_cmp
  import fgpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 16,
  parameter int CNT_W       = 16,
  parameter int LOCK_RUN    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_i,
  input  logic             ref_clk_i,
  input  logic             fb_i,
  input  logic [CNT_W-1:0] lock_limit_i,
  output logic             speed_up_o,
  output logic             slow_down_o,
  output logic             lock_raw_o
);
  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] fall_ev;
  logic              ref_fall;
  logic              fb_fall;
  logic              cmp_done;
  logic [CNT_W-1:0]  cmp_width;

  assign raw_in[CH_REF] = ref_clk_i;
  assign raw_in[CH_FB]  = fb_i;

  // identical filters keep the two paths at equal latency
  for (genvar g = 0; g < NUM_CH; g++) begin : g_in
    fgpc_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_in[g]),
      .fall_o(fall_ev[g])
    );
  end

  assign ref_fall = fall_ev[CH_REF];
  assign fb_fall  = fall_ev[CH_FB];

  fgpc_detector #(.CNT_W(CNT_W)) u_det (
    .clk       (clk),
    .rst       (rst),
    .stop_i    (stop_i),
    .ref_fall_i(ref_fall),
    .fb_fall_i (fb_fall),
    .up_o      (speed_up_o),
    .dn_o      (slow_down_o),
    .done_o    (cmp_done),
    .width_o   (cmp_width)
  );

  fgpc_lock_qual #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .stop_i (stop_i),
    .done_i (cmp_done),
    .width_i(cmp_width),
    .limit_i(lock_limit_i),
    .lock_o (lock_raw_o)
  );
endmodule

// File: rtl/fgpc_chk.sv
`timescale 1ns/1ps
module fgpc_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_i,
  input logic             ref_fall,
  input logic             fb_fall,
  input logic             cmp_done,
  input logic [CNT_W-1:0] cmp_width,
  input logic [CNT_W-1:0] lock_limit_i,
  input logic             speed_up_o,
  input logic             slow_down_o,
  input logic             lock_raw_o
);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({speed_up_o, slow_down_o}));

  assert_up_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(speed_up_o) |-> $past(ref_fall));

  assert_up_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(speed_up_o) |-> $past(fb_fall || stop_i));

  assert_dn_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_down_o) |-> $past(fb_fall));

  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!speed_up_o && !slow_down_o && !lock_raw_o));

  assert_lock_on_cmp_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_raw_o) |-> $past(cmp_done));

  assert_lock_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (cmp_done && (cmp_width >= lock_limit_i)) |=> !lock_raw_o);
endmodule

bind fg_phase_cmp fgpc_chk #(.CNT_W(CNT_W)) u_fgpc_chk (
  .clk         (clk),
  .rst         (rst),
  .stop_i      (stop_i),
  .ref_fall    (ref_fall),
  .fb_fall     (fb_fall),
  .cmp_done    (cmp_done),
  .cmp_width   (cmp_width),
  .lock_limit_i(lock_limit_i),
  .speed_up_o  (speed_up_o),
  .slow_down_o (slow_down_o),
  .lock_raw_o  (lock_raw_o)
);

// File: tb/test_fg_phase_cmp.sv
`timescale 1ns/1ps
module test_fg_phase_cmp;
  localparam int FILT  = 4;
  localparam int CW    = 6;
  localparam int RUN   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_r = 1'b0;
  logic ref_r = 1'b1;
  logic fb_r = 1'b1;
  logic [CW-1:0] limit_r = CW'(10);
  logic up, dn, lk;

  int checks = 0;
  int fails = 0;
  int up_acc = 0;
  int dn_acc = 0;
  int ovl = 0;

  always #2.5 clk = ~clk;

  fg_phase_cmp #(.SYNC_STAGES(2), .FILT_LEN(FILT), .CNT_W(CW), .LOCK_RUN(RUN)) i_fg_phase_cmp (
    .clk(clk), .rst(rst), .stop_i(stop_r), .ref_clk_i(ref_r), .fb_i(fb_r),
    .lock_limit_i(limit_r), .speed_up_o(up), .slow_down_o(dn), .lock_raw_o(lk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (up) up_acc++;
    if (dn) dn_acc++;
    if (up && dn) ovl++;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // one comparison: first signal falls, the other d cycles later, then both rise
  task automatic run_pair(input bit ref_first, input int d);
    up_acc = 0; dn_acc = 0;
    for (int i = 0; i < d + FILT + 10; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (ref_first) ref_r = 1'b0; else fb_r = 1'b0;
      end
      if (i == d) begin ref_r = 1'b0; fb_r = 1'b0; end
      if (up) up_acc++;
      if (dn) dn_acc++;
      if (up && dn) ovl++;
    end
    @(negedge clk); ref_r = 1'b1; fb_r = 1'b1;
    settle(FILT + 8);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 up", int'(up), 0);
    check("R1 down", int'(dn), 0);
    check("R1 lock", int'(lk), 0);
  endtask

  task automatic t_ref_lead();
    run_pair(1'b1, 7);
    check("R2 up width 7", up_acc, 7);
    check("R2 down idle", dn_acc, 0);
    run_pair(1'b1, 1);
    check("R2 up width 1", up_acc, 1);
  endtask

  task automatic t_fb_lead();
    run_pair(1'b0, 12);
    check("R3 down width 12", dn_acc, 12);
    check("R3 up idle", up_acc, 0);
  endtask

  task automatic t_same();
    run_pair(1'b1, 0);
    check("R4 up", up_acc, 0);
    check("R4 down", dn_acc, 0);
  endtask

  task automatic t_rise_only();
    @(negedge clk); ref_r = 1'b0; fb_r = 1'b0;
    settle(FILT + 8);
    up_acc = 0; dn_acc = 0;
    @(negedge clk); ref_r = 1'b1;
    settle(9);
    fb_r = 1'b1;
    settle(FILT + 10);
    check("R5 rising edges up", up_acc, 0);
    check("R5 rising edges down", dn_acc, 0);
  endtask

  task automatic t_glitch();
    up_acc = 0; dn_acc = 0;
    @(negedge clk); ref_r = 1'b0;
    settle(FILT - 2);
    ref_r = 1'b1;
    settle(FILT + 8);
    fb_r = 1'b0;
    settle(FILT - 1);
    fb_r = 1'b1;
    settle(FILT + 8);
    check("R6 short ref low rejected", up_acc, 0);
    check("R6 short fb low rejected", dn_acc, 0);
  endtask

  task automatic t_multi_ref();
    up_acc = 0; dn_acc = 0;
    for (int i = 0; i < 60 + FILT + 10; i++) begin
      @(negedge clk);
      if (i == 0)  ref_r = 1'b0;
      if (i == 20) ref_r = 1'b1;
      if (i == 40) ref_r = 1'b0;
      if (i == 60) fb_r = 1'b0;
      if (up) up_acc++;
      if (dn) dn_acc++;
      if (up && dn) ovl++;
    end
    @(negedge clk); ref_r = 1'b1; fb_r = 1'b1;
    settle(FILT + 8);
    check("R8 up held over second ref edge", up_acc, 60);
    check("R8 down idle", dn_acc, 0);
  endtask

  task automatic good_run(input int n);
    for (int k = 0; k < n; k++) run_pair(k[0], 3);
  endtask

  task automatic t_lock();
    limit_r = CW'(10);
    good_run(RUN - 1);
    check("R9 no lock after 7 good", int'(lk), 0);
    good_run(1);
    check("R9 lock after 8 good", int'(lk), 1);
    run_pair(1'b1, 10);
    check("R10 width equal to limit clears lock", int'(lk), 0);
    good_run(RUN - 1);
    check("R10 run restarted", int'(lk), 0);
    good_run(1);
    check("R9 relock", int'(lk), 1);
  endtask

  task automatic t_sat();
    limit_r = CW'(20);
    run_pair(1'b1, 80);
    check("R12 up width beyond counter range", up_acc, 80);
    check("R12 saturated width clears lock", int'(lk), 0);
  endtask

  task automatic t_stop();
    limit_r = CW'(20);
    good_run(RUN);
    check("R11 lock before stop", int'(lk), 1);
    up_acc = 0; dn_acc = 0;
    @(negedge clk); ref_r = 1'b0;
    settle(FILT + 8);
    check("R11 request open before stop", int'(up), 1);
    stop_r = 1'b1;
    @(negedge clk);
    check("R11 up cleared by stop", int'(up), 0);
    check("R11 lock cleared by stop", int'(lk), 0);
    fb_r = 1'b0;
    settle(FILT + 8);
    ref_r = 1'b1; fb_r = 1'b1;
    settle(FILT + 8);
    up_acc = 0; dn_acc = 0;
    stop_r = 1'b0;
    settle(FILT + 8);
    check("R11 quiet after release up", up_acc, 0);
    check("R11 quiet after release down", dn_acc, 0);
    good_run(1);
    check("R11 run cleared by stop", int'(lk), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ref_lead();
    t_fb_lead();
    t_same();
    t_rise_only();
    t_glitch();
    t_multi_ref();
    t_lock();
    t_sat();
    t_stop();
    check("R7 no overlap cycles", ovl, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule